// File: doc/BRIEF.md
# Register Write-to-Read Interlock

This unit finds read-after-write hazards in a four-stage in-order pipeline: fetch, operand read, execute and write-back. The register file is written only in the write-back stage and read only in the operand-read stage. No value is forwarded between stages, so an instruction that reads a register must wait until every older instruction that writes that register has left write-back.

The unit keeps its own record of the destination register for the execute and write-back stages. That record is loaded from the operand-read instruction each time that instruction advances. Each cycle the unit compares the source fields of the operand-read instruction against this record. On a match it raises a stall, which freezes fetch and operand read, and it asks for a no-write bubble to be placed into execute.

A producer followed directly by its consumer costs two stall cycles. One independent instruction placed between them reduces the cost to one cycle. A counter adds one for every stall cycle, so the cost of two orderings of the same code can be compared.

Top module: `reg_interlock`

## Requirements
- R1: While `of_valid` is high, `stall` is high in any cycle where an enabled source field equals the destination of a writing instruction now in execute.
- R2: `stall` is also high when an enabled source field equals the destination of a writing instruction now in write-back. A write and a read of the same register in the same cycle counts as a hazard.
- R3: A consumer that follows its producer directly sees exactly two stall cycles. With one independent instruction between them it sees exactly one.
- R4: Register index 0 is never a hazard. A source field of 0 never stalls, and a write to register 0 is never recorded.
- R5: The following never cause a stall: a source whose enable is low, a destination whose write enable is low, and an empty operand-read slot (`of_valid` low).
- R6: `insert_bubble` is high in exactly the cycles where `stall` is high. A stalled instruction does not advance, and the execute slot loaded during a stall carries no write.
- R7: `stall_cycles` adds one on every clock edge at which `stall` is high and holds at all other edges. In a four-pair save sequence, interleaving two reads before each pair of stores saves 6 cycles compared with placing each store directly after its read.
- R8: After reset, `stall` is low, `stall_cycles` is 0 and no instruction is recorded in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| of_valid | input | 1 | An instruction occupies operand read |
| of_rd_a_en | input | 1 | Source A is used |
| of_rd_a | input | REG_W | Source A register index |
| of_rd_b_en | input | 1 | Source B is used |
| of_rd_b | input | REG_W | Source B register index |
| of_wr_en | input | 1 | The instruction writes a register |
| of_wr_dst | input | REG_W | Destination register index |
| stall | output | 1 | Hold fetch and operand read |
| insert_bubble | output | 1 | Load a no-write bubble into execute |
| stall_cycles | output | CNT_W | Count of stall cycles |

## Verification
`stall` and `insert_bubble` are combinational from the operand-read fields and the two recorded stages. They are therefore sampled on the falling edge of the cycle in which the instruction is presented. An instruction leaves operand read at time t; its write is visible to a consumer at t+3 at the earliest. The bench model uses that rule to compute each instruction's expected stall count before the instruction is driven, and pushes the count into a queue. The monitor counts stalled falling edges until the instruction advances, then compares the total with the queued value. `stall_cycles` is registered, so it is read only after the pipeline has been idle for several cycles and compared with the sum of the queued stall counts.

// File: rtl/reg_interlock.sv
module reg_interlock #(
  parameter int REG_W = 4,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             of_valid,
  input  logic             of_rd_a_en,
  input  logic [REG_W-1:0] of_rd_a,
  input  logic             of_rd_b_en,
  input  logic [REG_W-1:0] of_rd_b,
  input  logic             of_wr_en,
  input  logic [REG_W-1:0] of_wr_dst,
  output logic             stall,
  output logic             insert_bubble,
  output logic [CNT_W-1:0] stall_cycles
);
  localparam logic [REG_W-1:0] ZERO_REG = '0;

  logic             ex_wr, rs_wr;
  logic [REG_W-1:0] ex_dst, rs_dst;
  logic             hit_a, hit_b;

  function automatic logic pending(input logic en, input logic [REG_W-1:0] src,
                                   input logic ew, input logic [REG_W-1:0] ed,
                                   input logic rw, input logic [REG_W-1:0] rd);
    return en && (src != ZERO_REG) && ((ew && ed == src) || (rw && rd == src));
  endfunction

  assign hit_a         = pending(of_rd_a_en, of_rd_a, ex_wr, ex_dst, rs_wr, rs_dst);
  assign hit_b         = pending(of_rd_b_en, of_rd_b, ex_wr, ex_dst, rs_wr, rs_dst);
  assign stall         = of_valid && (hit_a || hit_b);
  assign insert_bubble = stall;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ex_wr        <= 1'b0;
      ex_dst       <= '0;
      rs_wr        <= 1'b0;
      rs_dst       <= '0;
      stall_cycles <= '0;
    end else begin
      ex_wr        <= of_valid && !stall && of_wr_en && (of_wr_dst != ZERO_REG);
      ex_dst       <= of_wr_dst;
      rs_wr        <= ex_wr;
      rs_dst       <= ex_dst;
      if (stall) stall_cycles <= stall_cycles + 1'b1;
    end
  end
endmodule

module reg_interlock_chk #(
  parameter int REG_W = 4,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             of_valid,
  input logic             of_rd_a_en,
  input logic [REG_W-1:0] of_rd_a,
  input logic             of_rd_b_en,
  input logic [REG_W-1:0] of_rd_b,
  input logic             of_wr_en,
  input logic [REG_W-1:0] of_wr_dst,
  input logic             stall,
  input logic             insert_bubble,
  input logic [CNT_W-1:0] stall_cycles,
  input logic             ex_wr
);
  a_r5_idle_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
    !of_valid |-> !stall);

  a_r4_zero_sources: assert property (@(posedge clk) disable iff (!rst_n)
    (of_valid && (!of_rd_a_en || of_rd_a == '0) && (!of_rd_b_en || of_rd_b == '0)) |-> !stall);

  a_r6_bubble_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !ex_wr);

  a_r6_bubble_matches: assert property (@(posedge clk) disable iff (!rst_n)
    insert_bubble == stall);

  a_r7_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> stall_cycles == $past(stall_cycles) + {{(CNT_W-1){1'b0}}, 1'b1});

  a_r7_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !stall |=> $stable(stall_cycles));

  a_r3_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    (of_valid && !stall && of_wr_en && of_wr_dst != '0) |=>
      (!(of_valid && of_rd_a_en && of_rd_a == $past(of_wr_dst)) || stall));
endmodule

bind reg_interlock reg_interlock_chk #(.REG_W(REG_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .of_valid(of_valid),
  .of_rd_a_en(of_rd_a_en), .of_rd_a(of_rd_a),
  .of_rd_b_en(of_rd_b_en), .of_rd_b(of_rd_b),
  .of_wr_en(of_wr_en), .of_wr_dst(of_wr_dst),
  .stall(stall), .insert_bubble(insert_bubble),
  .stall_cycles(stall_cycles), .ex_wr(ex_wr)
);

// File: tb/reg_interlock_tb.sv
`timescale 1ns/1ps
module reg_interlock_tb;
  localparam int REG_W = 4;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic of_valid = 1'b0, of_rd_a_en = 1'b0, of_rd_b_en = 1'b0, of_wr_en = 1'b0;
  logic [REG_W-1:0] of_rd_a = '0, of_rd_b = '0, of_wr_dst = '0;
  logic stall, insert_bubble;
  logic [CNT_W-1:0] stall_cycles;

  int checks = 0, fails = 0;
  int cyc = 0;
  int ready [16];
  int exp_q [$];
  int run_sum = 0;
  bit done = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  reg_interlock #(.REG_W(REG_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .of_valid(of_valid),
    .of_rd_a_en(of_rd_a_en), .of_rd_a(of_rd_a),
    .of_rd_b_en(of_rd_b_en), .of_rd_b(of_rd_b),
    .of_wr_en(of_wr_en), .of_wr_dst(of_wr_dst),
    .stall(stall), .insert_bubble(insert_bubble), .stall_cycles(stall_cycles)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic issue(input string req, input bit ae, input int a, input bit be, input int b,
                       input bit we, input int d);
    int p, e, n;
    p = cyc;
    e = p;
    if (ae && a != 0 && ready[a] > e) e = ready[a];
    if (be && b != 0 && ready[b] > e) e = ready[b];
    n = e - p;
    exp_q.push_back(n);
    run_sum += n;
    if (we && d != 0) ready[d] = e + 3;
    of_valid = 1; of_rd_a_en = ae; of_rd_a = REG_W'(a); of_rd_b_en = be; of_rd_b = REG_W'(b);
    of_wr_en = we; of_wr_dst = REG_W'(d);
    forever begin
      @(negedge clk);
      if (!stall) break;
    end
    @(posedge clk); #1;
    of_valid = 0;
  endtask

  task automatic idle(input int n);
    of_valid = 0;
    repeat (n) begin @(posedge clk); #1; end
  endtask

  int stall_run = 0;
  string cur_req = "R3";
  always @(negedge clk) if (rst_n) begin
    if (of_valid) begin
      if (stall) begin
        stall_run++;
        check("R6 bubble with stall", insert_bubble, 1);
      end else begin
        check({cur_req, " stall count"}, stall_run, exp_q.size() > 0 ? exp_q.pop_front() : -1);
        stall_run = 0;
      end
    end else begin
      check("R5 idle stall", stall, 0);
    end
  end

  initial begin
    int base, d_second, d_first;
    foreach (ready[i]) ready[i] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check("R8 reset stall", stall, 0);
    check("R8 reset count", stall_cycles, 0);
    @(posedge clk); #1;
    cur_req = "R8";
    issue("R8", 1, 5, 1, 6, 1, 7);
    idle(4);

    cur_req = "R1/R3";
    issue("R3", 0, 0, 0, 0, 1, 3);
    issue("R3", 1, 3, 0, 0, 1, 4);
    idle(4);
    cur_req = "R2/R3";
    issue("R3", 0, 0, 0, 0, 1, 3);
    issue("R3", 0, 0, 0, 0, 1, 9);
    issue("R2", 0, 0, 1, 3, 0, 0);
    idle(4);
    cur_req = "R4";
    issue("R4", 0, 0, 0, 0, 1, 0);
    issue("R4", 1, 0, 1, 0, 1, 2);
    idle(4);
    cur_req = "R5";
    issue("R5", 0, 0, 0, 0, 0, 6);
    issue("R5", 1, 6, 0, 0, 0, 0);
    issue("R5", 0, 0, 0, 0, 1, 8);
    issue("R5", 0, 8, 0, 8, 0, 0);
    idle(4);
    cur_req = "R6";
    issue("R6", 0, 0, 0, 0, 1, 10);
    issue("R6", 1, 10, 0, 0, 1, 11);
    issue("R6", 1, 11, 1, 10, 0, 0);
    idle(4);
    check("R7 counter total", stall_cycles, run_sum);

    cur_req = "R7";
    base = run_sum;
    for (int k = 0; k < 4; k++) begin
      issue("R7", 0, 0, 0, 0, 1, 1);
      issue("R7", 1, 1, 1, 2, 0, 0);
    end
    idle(4);
    d_second = run_sum - base;
    check("R7 counter after adjacent order", stall_cycles, run_sum);
    base = run_sum;
    for (int k = 0; k < 2; k++) begin
      issue("R7", 0, 0, 0, 0, 1, 1);
      issue("R7", 0, 0, 0, 0, 1, 3);
      issue("R7", 1, 1, 1, 2, 0, 0);
      issue("R7", 1, 3, 1, 2, 0, 0);
    end
    idle(4);
    d_first = run_sum - base;
    check("R7 counter after interleaved order", stall_cycles, run_sum);
    check("R7 ordering saving", d_second - d_first, 6);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule